// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block sits between a dual-role USB controller core and the system bus. It gathers the core's interrupt sources into two banks. The endpoint bank holds transmit endpoints in its low half and receive endpoints in its high half. The core bank holds eight core event lines plus a ninth event raised whenever the VBUS-drive request changes level. Each bank has a pending register, an enable mask, and separate addresses for setting enables, clearing enables and acknowledging pending bits. A single interrupt line goes high while any enabled source is pending.

The same register file holds a few other registers:
- a soft-reset control bit, which sends a reset pulse of fixed length to the wrapped core;
- a mode register, which can replace the PHY's ID pin with a software value;
- a PHY control word, whose OTG-disable bit starts out set;
- two storage words for transmit and receive mode.

Software uses a plain 32-bit register port. A write completes in the cycle that `bus_wr` is high. Read data is a combinational function of `bus_addr`. The port has no flow control.

Top module: `usb_irq_wrap`

## Requirements
- R1: Offset 0x00 reads a fixed nonzero revision value.
- R2: A pending bit is set by a 0-to-1 transition of its source, whether or not the source is enabled. A source held high does not set the bit again. Endpoint pending is read at 0x30 and core pending at 0x34.
- R3: Writing 1 to a bit at 0x30 or 0x34 clears that pending bit, and writing 0 leaves the bit unchanged. If a new event arrives in the same cycle as the clear, the bit stays set.
- R4: Enable masks are changed at 0x38 (endpoint, set), 0x3C (core, set), 0x40 (endpoint, clear) and 0x44 (core, clear). A 1 in the write data sets or clears that enable bit, and a 0 leaves it unchanged. Both the set and the clear address of a bank read back that bank's current mask.
- R5: `irq` is high exactly when some bit is both pending and enabled in either bank.
- R6: In the endpoint bank, bits 15:0 are transmit endpoints and bits 31:17 are receive endpoints. Bit 16 never becomes pending or enabled, and it reads as 0.
- R7: Core bank bits 7:0 follow `core_src[7:0]`. Core bit 8 becomes pending on every change of `vbus_drv`, whether rising or falling. Bit 0 at offset 0x18 reads the live `vbus_drv` level.
- R8: Writing 1 to bit 0 at offset 0x14 raises `core_rst` for exactly RST_CYCLES cycles, starting the cycle after the write. Bit 0 at 0x14 reads 1 while the pulse runs and clears itself after it.
- R9: Offset 0x E8 is the mode register: bit 7 selects the software ID and bit 8 holds the software ID value. When bit 7 is 1, `id_eff` equals bit 8; otherwise `id_eff` follows `phy_id`. All other bits of the mode register read 0.
- R10: Offset 0xE0 is a read/write PHY control word driven on `phy_ctrl`. Its reset value is 0x0020_0000, which has the OTG-disable bit 21 set.
- R11: Offsets 0x70 and 0x74 are read/write words driven on `tx_mode` and `rx_mode`, and both reset to 0.
- R12: Reads from unmapped offsets return 0, and writes to unmapped offsets change no register.
- R13: After reset, pending bits and enable masks are 0, and `irq` and `core_rst` are low.

(In R9 the offset is 0xE8.)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ep_src | input | 32 | Endpoint interrupt levels (TX 15:0, RX 31:17) |
| core_src | input | 8 | Core interrupt levels |
| vbus_drv | input | 1 | VBUS-drive request level from the core |
| phy_id | input | 1 | ID pin from the PHY |
| irq | output | 1 | Combined interrupt |
| core_rst | output | 1 | Reset pulse to the wrapped core |
| id_eff | output | 1 | ID value presented to the core |
| phy_ctrl | output | 32 | PHY control word |
| tx_mode | output | 32 | Transmit mode word |
| rx_mode | output | 32 | Receive mode word |

## Verification
Pending and enable state can be observed one cycle after the source edge or write that changed it. A lost edge, a repeated trigger or a wrong clear shows up at once in the pending readback and on `irq`, so the bench compares both against its model after every cycle of random traffic. A wrong reset counter shows as a `core_rst` pulse of the wrong length, and the bench measures that length cycle by cycle. A swapped mux select in the mode register shows on `id_eff` as soon as `phy_id` and the software value disagree.

// File: rtl/usb_irqw_pkg.sv
package usb_irqw_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_REV        = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL       = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT       = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_EP_PEND    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_CORE_PEND  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_EP_ENSET   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_CORE_ENSET = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_EP_ENCLR   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CORE_ENCLR = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_TXMODE     = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_RXMODE     = 8'h74;
  localparam logic [ADDR_W-1:0] OFS_PHY        = 8'hE0;
  localparam logic [ADDR_W-1:0] OFS_MODE       = 8'hE8;

  localparam int CTRL_RST_BIT = 0;
  localparam int MODE_OVR_BIT = 7;
  localparam int MODE_VAL_BIT = 8;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic ack;
  } bank_wr_t;
endpackage

// File: rtl/usbw_edge_rise.sv
module usbw_edge_rise #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/usbw_irq_bank.sv
module usbw_irq_bank
  import usb_irqw_pkg::*;
#(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  bank_wr_t     wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic         active
);
  logic [W-1:0] pend_kept;

  always_comb begin
    pend_kept = wr.ack ? (pend & ~wdata) : pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= (pend_kept | evt) & MASK;
      if (wr.en_set)      en <= (en | wdata) & MASK;
      else if (wr.en_clr) en <= en & ~wdata;
    end
  end

  assign active = |(pend & en);
endmodule

// File: rtl/usbw_rst_pulse.sv
module usbw_rst_pulse #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CW'(CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usb_irqw_pkg::*;
#(
  parameter int          CORE_SRC_W = 8,
  parameter logic [31:0] REV_ID     = 32'h4EA2_0800,
  parameter int          RST_CYCLES = 4,
  parameter logic [31:0] PHY_RST    = 32'h0020_0000,
  parameter logic [31:0] EP_MASK    = 32'hFFFE_FFFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [DATA_W-1:0]     ep_src,
  input  logic [CORE_SRC_W-1:0] core_src,
  input  logic                  vbus_drv,
  input  logic                  phy_id,
  output logic                  irq,
  output logic                  core_rst,
  output logic                  id_eff,
  output logic [DATA_W-1:0]     phy_ctrl,
  output logic [DATA_W-1:0]     tx_mode,
  output logic [DATA_W-1:0]     rx_mode
);
  localparam int CORE_W = CORE_SRC_W + 1;

  logic [DATA_W-1:0]     ep_rise, ep_pend, ep_en;
  logic [CORE_SRC_W-1:0] core_rise;
  logic [CORE_W-1:0]     core_evt, core_pend, core_en;
  logic                  ep_act, core_act;
  logic                  vbus_q;
  logic                  mode_ovr, mode_val;
  bank_wr_t              ep_wr, core_wr;
  logic                  rst_start;

  function automatic logic hit(input logic [ADDR_W-1:0] ofs);
    return bus_wr && (bus_addr == ofs);
  endfunction

  usbw_edge_rise #(.W(DATA_W)) u_ep_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ep_src), .rise(ep_rise)
  );

  usbw_edge_rise #(.W(CORE_SRC_W)) u_core_edge (
    .clk(clk), .rst_n(rst_n), .lvl(core_src), .rise(core_rise)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) vbus_q <= 1'b0;
    else        vbus_q <= vbus_drv;
  end

  assign core_evt = {vbus_drv ^ vbus_q, core_rise};

  always_comb begin
    ep_wr.en_set   = hit(OFS_EP_ENSET);
    ep_wr.en_clr   = hit(OFS_EP_ENCLR);
    ep_wr.ack      = hit(OFS_EP_PEND);
    core_wr.en_set = hit(OFS_CORE_ENSET);
    core_wr.en_clr = hit(OFS_CORE_ENCLR);
    core_wr.ack    = hit(OFS_CORE_PEND);
  end

  usbw_irq_bank #(.W(DATA_W), .MASK(EP_MASK)) u_ep_bank (
    .clk(clk), .rst_n(rst_n), .evt(ep_rise), .wr(ep_wr),
    .wdata(bus_wdata), .pend(ep_pend), .en(ep_en), .active(ep_act)
  );

  usbw_irq_bank #(.W(CORE_W), .MASK({CORE_W{1'b1}})) u_core_bank (
    .clk(clk), .rst_n(rst_n), .evt(core_evt), .wr(core_wr),
    .wdata(bus_wdata[CORE_W-1:0]), .pend(core_pend), .en(core_en),
    .active(core_act)
  );

  assign irq = ep_act | core_act;

  assign rst_start = hit(OFS_CTRL) && bus_wdata[CTRL_RST_BIT];

  usbw_rst_pulse #(.CYC(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .busy(core_rst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_ovr <= 1'b0;
      mode_val <= 1'b0;
      phy_ctrl <= PHY_RST;
      tx_mode  <= '0;
      rx_mode  <= '0;
    end else begin
      if (hit(OFS_MODE)) begin
        mode_ovr <= bus_wdata[MODE_OVR_BIT];
        mode_val <= bus_wdata[MODE_VAL_BIT];
      end
      if (hit(OFS_PHY))    phy_ctrl <= bus_wdata;
      if (hit(OFS_TXMODE)) tx_mode  <= bus_wdata;
      if (hit(OFS_RXMODE)) rx_mode  <= bus_wdata;
    end
  end

  assign id_eff = mode_ovr ? mode_val : phy_id;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_REV:        bus_rdata = REV_ID;
      OFS_CTRL:       bus_rdata[CTRL_RST_BIT] = core_rst;
      OFS_STAT:       bus_rdata[0] = vbus_drv;
      OFS_EP_PEND:    bus_rdata = ep_pend;
      OFS_CORE_PEND:  bus_rdata[CORE_W-1:0] = core_pend;
      OFS_EP_ENSET,
      OFS_EP_ENCLR:   bus_rdata = ep_en;
      OFS_CORE_ENSET,
      OFS_CORE_ENCLR: bus_rdata[CORE_W-1:0] = core_en;
      OFS_TXMODE:     bus_rdata = tx_mode;
      OFS_RXMODE:     bus_rdata = rx_mode;
      OFS_PHY:        bus_rdata = phy_ctrl;
      OFS_MODE: begin
        bus_rdata[MODE_OVR_BIT] = mode_ovr;
        bus_rdata[MODE_VAL_BIT] = mode_val;
      end
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [7:0]    bus_addr,
  input logic          wbit0,
  input logic          vbus_drv,
  input logic          irq,
  input logic          core_rst,
  input logic          id_eff,
  input logic [31:0]   ep_pend,
  input logic [31:0]   ep_en,
  input logic [CW-1:0] core_pend,
  input logic [CW-1:0] core_en,
  input logic          mode_ovr,
  input logic          mode_val
);
  assert_ack_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr && bus_addr == 8'h30) |->
      ((ep_pend & $past(ep_pend)) == $past(ep_pend)));

  assert_irq_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((|(ep_pend & ep_en)) || (|(core_pend & core_en))));

  assert_rsvd_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_pend[16] && !ep_en[16]);

  assert_vbus_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_drv != $past(vbus_drv)) |=> core_pend[CW-1]);

  assert_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> $past(bus_wr && bus_addr == 8'h14 && wbit0));

  assert_id_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ovr |-> (id_eff == mode_val));
endmodule

bind usb_irq_wrap usb_irq_wrap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wbit0(bus_wdata[0]), .vbus_drv(vbus_drv), .irq(irq),
  .core_rst(core_rst), .id_eff(id_eff), .ep_pend(ep_pend), .ep_en(ep_en),
  .core_pend(core_pend), .core_en(core_en), .mode_ovr(mode_ovr),
  .mode_val(mode_val)
);

// File: tb/usb_irq_wrap_tb.sv
`timescale 1ns/100ps
module usb_irq_wrap_tb;
  localparam int          RST_CYC = 4;
  localparam logic [31:0] EPM     = 32'hFFFE_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ep_src = '0;
  logic [7:0]  core_src = '0;
  logic        vbus_drv = 1'b0;
  logic        phy_id = 1'b0;
  logic        irq, core_rst, id_eff;
  logic [31:0] phy_ctrl, tx_mode, rx_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_ep_pend = '0, m_ep_en = '0, prev_ep = '0;
  logic [8:0]  m_c_pend = '0, m_c_en = '0;
  logic [7:0]  prev_c = '0;
  logic        prev_vb = 1'b0;

  always #2 clk = ~clk;

  usb_irq_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_src(ep_src),
    .core_src(core_src), .vbus_drv(vbus_drv), .phy_id(phy_id), .irq(irq),
    .core_rst(core_rst), .id_eff(id_eff), .phy_ctrl(phy_ctrl),
    .tx_mode(tx_mode), .rx_mode(rx_mode)
  );

  function automatic logic exp_irq();
    return (|(m_ep_pend & m_ep_en)) || (|(m_c_pend & m_c_en));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  task automatic step(input logic [31:0] ep, input logic [7:0] cs, input logic vb,
                      input logic wr, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] evt_ep;
    logic [8:0]  evt_c;
    ep_src = ep; core_src = cs; vbus_drv = vb;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    evt_ep = ep & ~prev_ep & EPM;
    evt_c  = {vb ^ prev_vb, cs & ~prev_c};
    if (wr && a == 8'h38) m_ep_en = (m_ep_en | d) & EPM;
    if (wr && a == 8'h40) m_ep_en = m_ep_en & ~d;
    if (wr && a == 8'h3C) m_c_en = m_c_en | d[8:0];
    if (wr && a == 8'h44) m_c_en = m_c_en & ~d[8:0];
    m_ep_pend = (((wr && a == 8'h30) ? (m_ep_pend & ~d) : m_ep_pend) | evt_ep) & EPM;
    m_c_pend  = ((wr && a == 8'h34) ? (m_c_pend & ~d[8:0]) : m_c_pend) | evt_c;
    prev_ep = ep; prev_c = cs; prev_vb = vb;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic idle();
    step(ep_src, core_src, vbus_drv, 1'b0, 8'h00, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(ep_src, core_src, vbus_drv, 1'b1, a, d);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R13 reset state
    check("R13 irq", {31'b0, irq}, 32'h0);
    check("R13 core_rst", {31'b0, core_rst}, 32'h0);
    rd(8'h30, v); check("R13 ep pend", v, 32'h0);
    rd(8'h3C, v); check("R13 core en", v, 32'h0);
    // R1 revision
    rd(8'h00, v); check("R1 revision nonzero", {31'b0, v != 0}, 32'h1);
    // R10 PHY reset value
    rd(8'hE0, v); check("R10 phy reset read", v, 32'h0020_0000);
    check("R10 phy port", phy_ctrl, 32'h0020_0000);
    // R11 reset
    check("R11 tx reset", tx_mode, 32'h0);

    // R2 latch without enable, no retrigger while held
    step(32'h1, 8'h0, 1'b0, 1'b0, 8'h0, 32'h0);
    rd(8'h30, v); check("R2 pend latched disabled", v, 32'h1);
    check("R2 irq low while disabled", {31'b0, irq}, 32'h0);
    step(32'h1, 8'h0, 1'b0, 1'b1, 8'h30, 32'h1);
    rd(8'h30, v); check("R2 held level no retrigger", v, 32'h0);

    // R4 enable set/clear semantics
    wr(8'h38, 32'h0002_0001);
    rd(8'h38, v); check("R4 set readback", v, 32'h0002_0001);
    rd(8'h40, v); check("R4 clear addr readback", v, 32'h0002_0001);
    wr(8'h38, 32'h0000_0004);
    rd(8'h38, v); check("R4 zeros unchanged", v, 32'h0002_0005);
    wr(8'h40, 32'h0000_0001);
    rd(8'h40, v); check("R4 clear one bit", v, 32'h0002_0004);

    // R6 reserved bit
    step(32'hFFFF_FFFF, 8'h0, 1'b0, 1'b1, 8'h38, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R6 pend bit16 reserved", v, m_ep_pend);
    rd(8'h38, v); check("R6 enable bit16 reserved", v, 32'hFFFE_FFFF);
    check("R5 irq high", {31'b0, irq}, {31'b0, exp_irq()});
    step(32'h0, 8'h0, 1'b0, 1'b1, 8'h30, 32'hFFFF_FFFF);
    check("R5 irq after ack", {31'b0, irq}, 32'h0);

    // R3 set wins over simultaneous clear
    step(32'h2, 8'h0, 1'b0, 1'b0, 8'h0, 32'h0);
    step(32'h0, 8'h0, 1'b0, 1'b0, 8'h0, 32'h0);
    step(32'h2, 8'h0, 1'b0, 1'b1, 8'h30, 32'h2);
    rd(8'h30, v); check("R3 new event beats ack", v, 32'h2);
    step(32'h2, 8'h0, 1'b0, 1'b1, 8'h30, 32'h0);
    rd(8'h30, v); check("R3 write zero keeps", v, 32'h2);
    wr(8'h30, 32'h2);
    rd(8'h30, v); check("R3 w1c clears", v, 32'h0);

    // R7 VBUS change both directions
    step(32'h0, 8'h0, 1'b1, 1'b0, 8'h0, 32'h0);
    rd(8'h34, v); check("R7 vbus rise pend", v, 32'h100);
    rd(8'h18, v); check("R7 status level high", v, 32'h1);
    wr(8'h34, 32'h100);
    step(32'h0, 8'h0, 1'b0, 1'b0, 8'h0, 32'h0);
    rd(8'h34, v); check("R7 vbus fall pend", v, 32'h100);
    rd(8'h18, v); check("R7 status level low", v, 32'h0);
    wr(8'h34, 32'h1FF);

    // R8 reset pulse length
    wr(8'h14, 32'h1);
    for (int i = 0; i <= RST_CYC; i++) begin
      check("R8 core_rst pulse", {31'b0, core_rst}, {31'b0, i < RST_CYC});
      rd(8'h14, v); check("R8 ctrl bit readback", v, {31'b0, i < RST_CYC});
      idle();
    end

    // R9 ID override
    phy_id = 1'b1;
    wr(8'hE8, 32'h080);
    check("R9 override host", {31'b0, id_eff}, 32'h0);
    wr(8'hE8, 32'hFFFF_FFFF);
    check("R9 override peripheral", {31'b0, id_eff}, 32'h1);
    rd(8'hE8, v); check("R9 mode readback", v, 32'h180);
    wr(8'hE8, 32'h100);
    check("R9 follows pin high", {31'b0, id_eff}, 32'h1);
    phy_id = 1'b0; #0.2;
    check("R9 follows pin low", {31'b0, id_eff}, 32'h0);

    // R10 / R11 storage
    wr(8'hE0, 32'h0000_0002);
    rd(8'hE0, v); check("R10 phy write", v, 32'h2);
    check("R10 phy port", phy_ctrl, 32'h2);
    wr(8'h70, 32'hA5A5_0F0F);
    wr(8'h74, 32'h1234_5678);
    rd(8'h70, v); check("R11 tx readback", v, 32'hA5A5_0F0F);
    rd(8'h74, v); check("R11 rx readback", v, 32'h1234_5678);
    check("R11 rx port", rx_mode, 32'h1234_5678);

    // R12 unmapped
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h3A, 32'hFFFF_FFFF);
    rd(8'h48, v); check("R12 unmapped read", v, 32'h0);
    rd(8'h38, v); check("R12 ep en untouched", v, m_ep_en);
    rd(8'h3C, v); check("R12 core en untouched", v, {23'b0, m_c_en});
    check("R12 tx untouched", tx_mode, 32'hA5A5_0F0F);

    // Random traffic against the model (R2 R3 R4 R5)
    for (int n = 0; n < 500; n++) begin
      logic [31:0] ep, d;
      logic [7:0]  cs, a;
      logic        vb, w;
      int          op;
      ep = prev_ep ^ ($urandom & $urandom & $urandom);
      cs = prev_c ^ 8'($urandom & $urandom);
      vb = (($urandom % 8) == 0) ? ~prev_vb : prev_vb;
      op = $urandom % 8;
      d  = $urandom;
      w  = (op < 6);
      case (op)
        0: a = 8'h30;
        1: a = 8'h34;
        2: a = 8'h38;
        3: a = 8'h3C;
        4: a = 8'h40;
        5: a = 8'h44;
        default: a = 8'h00;
      endcase
      step(ep, cs, vb, w, a, d);
      check("R5 random irq", {31'b0, irq}, {31'b0, exp_irq()});
      rd(8'h30, v); check("R2 random ep pend", v, m_ep_pend);
      rd(8'h34, v); check("R3 random core pend", v, {23'b0, m_c_pend});
      rd(8'h40, v); check("R4 random ep en", v, m_ep_en);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule